// File: doc/BRIEF.md
# PHY Configuration and Scrambler Seed Registers

This block holds two 16-bit management registers of a 100 Mbit PHY, decoded at register addresses 18h and 19h. The first carries the control bits for the physical layer: a far-end-fault enable, a forced-good-link bit, a halt-symbol pass-through bit, a burst-mode bit and a self-clearing seed-load command. The far-end-fault enable comes out of reset at the level of a strap pin. After reset it can only be changed while a fiber-select override input is high.

The second register holds a 6-bit user seed and a 5-bit PHY address. The top three address bits are taken from strap pins during reset. The lower two are taken from the port index. When software sets the seed-load bit, the block copies the 11 bits formed by the seed and the address onto a scrambler seed port and pulses a load strobe for one cycle. A load waits while a transmit is in progress and runs on the first idle cycle. The block also gives the scrambler lock timeout as a clock-cycle count, and burst mode selects the longer of the two periods.

Access goes through a simple port: an address, a write enable with write data, and combinational read data for the current address.

Top module: `phy_cfg_regs`

## Requirements
- R1: During and after reset, register 18h reads 0 except bit 11, which equals `strap_fefi`. Register 19h reads 0000_0 in bits 15:11, 6'h21 in bits 10:5 and `{strap_addr_hi, port_idx}` in bits 4:0.
- R2: In register 18h, bit 9 (force good link), bit 5 (accept halt) and bit 3 (burst) take the written value at the write edge. Bits 15:12, 10, 8:6 and 2:0 always read 0.
- R3: Bit 11 of register 18h (far-end-fault enable) takes the written value only when `fiber_ovr` is 1 in the write cycle. Otherwise the bit keeps its value.
- R4: Writing 1 to bit 4 of 18h while `tx_active` is 0 raises `seed_load` for exactly one cycle, starting one cycle after the write edge. During that cycle `seed_out` equals bits 10:0 of register 19h.
- R5: While `tx_active` is 1, a pending load produces no `seed_load`. The strobe rises one cycle after the first clock edge at which `tx_active` is 0. It carries the value of register 19h at that edge.
- R6: Bit 4 of 18h reads 1 from the write edge through the strobe cycle, and 0 from the cycle after the strobe. Writing 0 to bit 4 does not cancel a pending load.
- R7: `timeout_cycles` equals 722×CLK_MHZ while burst is 0 and 2000×CLK_MHZ while burst is 1, which is 180500 and 500000 at 250 MHz.
- R8: In register 19h, bits 10:0 are writable and bits 15:11 always read 0.
- R9: Reads of any address other than 18h and 19h return 0. Writes to such an address change neither register.
- R10: `fefi_en`, `force_link` and `pass_halt` follow bits 11, 9 and 5 of register 18h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| addr | input | 5 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the addressed register |
| strap_fefi | input | 1 | Reset level of the far-end-fault enable |
| strap_addr_hi | input | 3 | Strapped upper PHY address bits |
| port_idx | input | 2 | Port index, used as the lower PHY address bits |
| fiber_ovr | input | 1 | Override that unlocks writes to the far-end-fault enable |
| tx_active | input | 1 | High while a transmit is in progress |
| seed_out | output | 11 | Seed presented to the scrambler |
| seed_load | output | 1 | One-cycle strobe that loads `seed_out` |
| timeout_cycles | output | 19 | Scrambler lock timeout in clock cycles |
| fefi_en | output | 1 | Far-end-fault enable |
| force_link | output | 1 | Force good link in 100 Mbit mode |
| pass_halt | output | 1 | Pass halt symbols to the receive side |

## Verification
The bench writes the far-end-fault enable with the override low and then high. A design that ignores the lock would lose the strapped 1. It then holds a seed load pending across several transmit-busy cycles. A design that fires the load early or cancels it would strobe during transmit, or drop bit 4 after a write of 0. During that wait it rewrites register 19h to prove the seed is captured at the strobe and not at the command. A design that latches the seed at the write would present the stale value. The strobe width, the clear of bit 4 one cycle later, the reserved fields, the unmapped address and both timeout counts are checked cycle by cycle.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
    localparam logic [4:0] ADDR_CFG = 5'h18;
    localparam logic [4:0] ADDR_ID  = 5'h19;

    localparam int B_FEFI  = 11;
    localparam int B_FGL   = 9;
    localparam int B_HALT  = 5;
    localparam int B_LD    = 4;
    localparam int B_BURST = 3;

    localparam int SEED_W     = 6;
    localparam int PADDR_W    = 5;
    localparam int PADDR_HI_W = 3;
    localparam int PADDR_LO_W = PADDR_W - PADDR_HI_W;
    localparam int LOAD_W     = SEED_W + PADDR_W;
    localparam logic [SEED_W-1:0] SEED_RST = 6'h21;

    typedef struct packed {
        logic fefi;
        logic fgl;
        logic halt;
        logic ld;
        logic burst;
    } cfg_t;

    typedef struct packed {
        logic [SEED_W-1:0]  seed;
        logic [PADDR_W-1:0] paddr;
    } id_t;

    typedef struct packed {
        logic              stb;
        logic [LOAD_W-1:0] seed;
    } seq_t;
endpackage

// File: rtl/phy_cfg_ctl.sv
module phy_cfg_ctl
    import phy_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_fefi,
    input  logic fiber_ovr,
    input  logic wr_cfg,
    input  cfg_t wr_bits,
    input  logic load_done,
    output cfg_t cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_done) begin
            cfg_d.ld = 1'b0;
        end
        if (wr_cfg) begin
            cfg_d.fgl   = wr_bits.fgl;
            cfg_d.halt  = wr_bits.halt;
            cfg_d.burst = wr_bits.burst;
            if (fiber_ovr) begin
                cfg_d.fefi = wr_bits.fefi;
            end
            if (wr_bits.ld) begin
                cfg_d.ld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{fefi: strap_fefi, default: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/phy_id_reg.sv
module phy_id_reg
    import phy_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PADDR_HI_W-1:0] strap_addr_hi,
    input  logic [PADDR_LO_W-1:0] port_idx,
    input  logic                  wr_id,
    input  id_t                   wr_bits,
    output id_t                   id
);
    id_t id_d, id_q;

    always_comb begin
        id_d = id_q;
        if (wr_id) begin
            id_d = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q.seed  <= SEED_RST;
            id_q.paddr <= {strap_addr_hi, port_idx};
        end else begin
            id_q <= id_d;
        end
    end

    assign id = id_q;
endmodule

// File: rtl/phy_seed_seq.sv
module phy_seed_seq
    import phy_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_pend,
    input  logic              tx_active,
    input  logic [LOAD_W-1:0] seed_src,
    input  logic [LOAD_W-1:0] seed_init,
    output logic [LOAD_W-1:0] seed_out,
    output logic              seed_load
);
    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.stb = ld_pend & ~tx_active & ~seq_q.stb;
        if (seq_d.stb) begin
            seq_d.seed = seed_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.stb  <= 1'b0;
            seq_q.seed <= seed_init;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seed_out  = seq_q.seed;
    assign seed_load = seq_q.stb;
endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
    import phy_cfg_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int NORM_US  = 722,
    parameter int BURST_US = 2000,
    parameter int TMO_W    = $clog2(BURST_US * CLK_MHZ + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4:0]            addr,
    input  logic                  wr_en,
    input  logic [15:0]           wr_data,
    output logic [15:0]           rd_data,
    input  logic                  strap_fefi,
    input  logic [2:0]            strap_addr_hi,
    input  logic [1:0]            port_idx,
    input  logic                  fiber_ovr,
    input  logic                  tx_active,
    output logic [10:0]           seed_out,
    output logic                  seed_load,
    output logic [TMO_W-1:0]      timeout_cycles,
    output logic                  fefi_en,
    output logic                  force_link,
    output logic                  pass_halt
);
    localparam int TMO_NORM  = NORM_US * CLK_MHZ;
    localparam int TMO_BURST = BURST_US * CLK_MHZ;

    cfg_t cfg, cfg_wr;
    id_t  id, id_wr;
    logic wr_cfg, wr_id;
    logic ld_pend;
    logic unused_wr_bits;

    assign wr_cfg = wr_en && (addr == ADDR_CFG);
    assign wr_id  = wr_en && (addr == ADDR_ID);

    assign cfg_wr = '{fefi:  wr_data[B_FEFI],
                      fgl:   wr_data[B_FGL],
                      halt:  wr_data[B_HALT],
                      ld:    wr_data[B_LD],
                      burst: wr_data[B_BURST]};
    assign id_wr  = wr_data[LOAD_W-1:0];
    assign unused_wr_bits = ^{wr_data[15:12], wr_data[10], wr_data[8:6], wr_data[2:0]};

    phy_cfg_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_fefi (strap_fefi),
        .fiber_ovr  (fiber_ovr),
        .wr_cfg     (wr_cfg),
        .wr_bits    (cfg_wr),
        .load_done  (seed_load),
        .cfg        (cfg)
    );

    phy_id_reg u_id (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_addr_hi (strap_addr_hi),
        .port_idx      (port_idx),
        .wr_id         (wr_id),
        .wr_bits       (id_wr),
        .id            (id)
    );

    assign ld_pend = cfg.ld;

    phy_seed_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_pend   (ld_pend),
        .tx_active (tx_active),
        .seed_src  (id),
        .seed_init ({SEED_RST, strap_addr_hi, port_idx}),
        .seed_out  (seed_out),
        .seed_load (seed_load)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CFG: begin
                rd_data[B_FEFI]  = cfg.fefi;
                rd_data[B_FGL]   = cfg.fgl;
                rd_data[B_HALT]  = cfg.halt;
                rd_data[B_LD]    = cfg.ld;
                rd_data[B_BURST] = cfg.burst;
            end
            ADDR_ID: rd_data[LOAD_W-1:0] = id;
            default: rd_data = '0;
        endcase
    end

    assign timeout_cycles = cfg.burst ? TMO_W'(TMO_BURST) : TMO_W'(TMO_NORM);
    assign fefi_en    = cfg.fefi;
    assign force_link = cfg.fgl;
    assign pass_halt  = cfg.halt;
endmodule

// File: rtl/phy_cfg_regs_chk.sv
module phy_cfg_regs_chk #(
    parameter int CLK_MHZ  = 250,
    parameter int NORM_US  = 722,
    parameter int BURST_US = 2000,
    parameter int TMO_W    = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       addr,
    input logic [15:0]      rd_data,
    input logic             fiber_ovr,
    input logic             fefi_en,
    input logic             tx_active,
    input logic             seed_load,
    input logic             ld_pend,
    input logic [TMO_W-1:0] timeout_cycles
);
    localparam logic [TMO_W-1:0] T_NORM  = TMO_W'(NORM_US * CLK_MHZ);
    localparam logic [TMO_W-1:0] T_BURST = TMO_W'(BURST_US * CLK_MHZ);

    assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h18) |-> (rd_data[15:12] == 4'd0 && rd_data[10] == 1'b0 &&
                             rd_data[8:6] == 3'd0 && rd_data[2:0] == 3'd0));

    assert_fefi_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fiber_ovr |=> (fefi_en == $past(fefi_en)));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> !seed_load);

    assert_no_load_in_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |-> !$past(tx_active));

    assert_pend_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |-> ld_pend);

    assert_tmo_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h18) |-> (timeout_cycles == (rd_data[3] ? T_BURST : T_NORM)));
endmodule

bind phy_cfg_regs phy_cfg_regs_chk #(
    .CLK_MHZ  (CLK_MHZ),
    .NORM_US  (NORM_US),
    .BURST_US (BURST_US),
    .TMO_W    (TMO_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .rd_data        (rd_data),
    .fiber_ovr      (fiber_ovr),
    .fefi_en        (fefi_en),
    .tx_active      (tx_active),
    .seed_load      (seed_load),
    .ld_pend        (ld_pend),
    .timeout_cycles (timeout_cycles)
);

// File: tb/phy_cfg_regs_tb.sv
module phy_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = 5'h0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        strap_fefi = 1'b1;
    logic [2:0]  strap_addr_hi = 3'b101;
    logic [1:0]  port_idx = 2'b10;
    logic        fiber_ovr = 1'b0;
    logic        tx_active = 1'b0;
    logic [10:0] seed_out;
    logic        seed_load;
    logic [18:0] timeout_cycles;
    logic        fefi_en, force_link, pass_halt;

    int total = 0;
    int bad = 0;
    logic rd_vld = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    phy_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .strap_fefi(strap_fefi), .strap_addr_hi(strap_addr_hi),
        .port_idx(port_idx), .fiber_ovr(fiber_ovr), .tx_active(tx_active),
        .seed_out(seed_out), .seed_load(seed_load), .timeout_cycles(timeout_cycles),
        .fefi_en(fefi_en), .force_link(force_link), .pass_halt(pass_halt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: present a read address and queue the expected value
    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_vld = 1'b1;
        @(negedge clk); #1;
        rd_vld = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // monitor: compare the read port against the scoreboard
    always @(negedge clk) begin
        if (rd_vld && exp_q.size() > 0) begin
            check(tag_q.pop_front(), {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
        end
    end

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset contents
        rd(5'h18, 16'h0800, "R1 cfg reset");
        rd(5'h19, 16'h0436, "R1 id reset");
        @(negedge clk);
        check("R1 seed_out reset", {21'h0, seed_out}, 32'h436);
        check("R7 timeout normal", {13'h0, timeout_cycles}, 32'd180500);

        // R2 R3 R7 R10: override low, fefi locked
        fiber_ovr = 1'b0;
        wr(5'h18, 16'h0000);
        rd(5'h18, 16'h0800, "R3 fefi locked clear");
        wr(5'h18, 16'hFFEF);
        rd(5'h18, 16'h0A28, "R2 writable and reserved bits");
        @(negedge clk);
        check("R7 timeout burst", {13'h0, timeout_cycles}, 32'd500000);
        check("R10 mirrors", {29'h0, fefi_en, force_link, pass_halt}, 32'h7);

        // R3 override high
        fiber_ovr = 1'b1;
        wr(5'h18, 16'h0000);
        rd(5'h18, 16'h0000, "R3 fefi write with override");
        @(negedge clk);
        check("R10 mirrors cleared", {29'h0, fefi_en, force_link, pass_halt}, 32'h0);
        check("R7 timeout back to normal", {13'h0, timeout_cycles}, 32'd180500);
        wr(5'h18, 16'h0800);
        rd(5'h18, 16'h0800, "R3 fefi set with override");
        fiber_ovr = 1'b0;

        // R8 id register
        wr(5'h19, 16'hFFFF);
        rd(5'h19, 16'h07FF, "R8 id reserved");
        wr(5'h19, 16'h0545);
        rd(5'h19, 16'h0545, "R8 id write");

        // R9 unmapped address
        wr(5'h10, 16'hFFEF);
        rd(5'h10, 16'h0000, "R9 unmapped read");
        rd(5'h18, 16'h0800, "R9 cfg untouched");
        rd(5'h19, 16'h0545, "R9 id untouched");

        // R4 R6 idle seed load
        wr(5'h18, 16'h0810);
        @(negedge clk);
        check("R4 no strobe at write edge", {31'h0, seed_load}, 32'h0);
        check("R6 pending bit", {31'h0, rd_data[4]}, 32'h1);
        @(negedge clk);
        check("R4 strobe", {31'h0, seed_load}, 32'h1);
        check("R4 seed value", {21'h0, seed_out}, 32'h545);
        check("R6 bit held in strobe", {31'h0, rd_data[4]}, 32'h1);
        @(negedge clk);
        check("R4 strobe one cycle", {31'h0, seed_load}, 32'h0);
        check("R6 bit cleared", {31'h0, rd_data[4]}, 32'h0);

        // R5 R6 hold off during transmit
        @(posedge clk); #1 tx_active = 1'b1;
        wr(5'h18, 16'h0810);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R5 no strobe while tx", {31'h0, seed_load}, 32'h0);
        end
        wr(5'h18, 16'h0800);
        @(negedge clk);
        check("R6 write 0 keeps pending", {31'h0, rd_data[4]}, 32'h1);
        wr(5'h19, 16'h0123);
        addr = 5'h18;
        @(negedge clk);
        check("R5 still held", {31'h0, seed_load}, 32'h0);
        @(posedge clk); #1 tx_active = 1'b0;
        @(negedge clk);
        check("R5 strobe waits one edge", {31'h0, seed_load}, 32'h0);
        @(negedge clk);
        check("R5 strobe after idle", {31'h0, seed_load}, 32'h1);
        check("R5 seed captured late", {21'h0, seed_out}, 32'h123);
        @(negedge clk);
        check("R5 strobe ends", {31'h0, seed_load}, 32'h0);
        check("R6 cleared after held load", {31'h0, rd_data[4]}, 32'h0);
        check("R6 seed_out kept", {21'h0, seed_out}, 32'h123);

        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule